// File: doc/BRIEF.md
# Hot-Spot Activity Migration Controller

This controller sits beside a hot-spot execution unit and an identical copy of it, placed elsewhere on the die. It keeps only one of the two copies working at any time and cuts the active power of the other so that it can cool. From time to time it moves the work to the other copy. A move can be started in two ways: by a fixed count of run cycles, or by the working copy's temperature reading rising above a programmed limit.

Every move follows the same sequence. The controller first raises a stall that stops new work from being issued. It then waits for the working copy to report that its in-flight operations have drained. Next it offers the architectural-state transfer to a copy engine through a valid/ready handshake and waits for the engine's done pulse. Only after that pulse does it enable the other copy, release the stall and power-gate the copy that was working. Reset always leaves the original unit (index 0) in charge. The index of the working copy and a saturating count of finished moves are available as outputs.

Top module: `heat_pingpong_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `active_o` is 0, `unit_en_o` is 2'b01, `unit_gate_o` is 2'b10, `issue_stall_o` is 0, `copy_valid_o` is 0 and `mig_count_o` is 0.
- R2: `unit_en_o` always has exactly one bit set. While `issue_stall_o` is low, `unit_gate_o` is the bitwise inverse of `unit_en_o`.
- R3: With `trig_sensor_i` = 0 (periodic mode) and `period_i` = P > 0, `issue_stall_o` stays low for exactly P cycles after reset or after a handover, and rises in cycle P+1.
- R4: With `period_i` = 0, no move ever starts, in either mode: `issue_stall_o` stays low and `active_o` does not change.
- R5: With `trig_sensor_i` = 1 (sensor mode) and `period_i` > 0, a move starts in the cycle after a clock edge at which the working unit's temperature (`temp0_i` if `active_o` = 0, else `temp1_i`) is strictly greater than `threshold_i`. An equal reading does not start a move, and neither does the idle unit's reading.
- R6: Once a move has started, `issue_stall_o` is high and `copy_valid_o` stays low up to and including the cycle in which `drain_done_i` is sampled high. `copy_valid_o` rises in the next cycle.
- R7: `copy_valid_o` stays high until it is sampled together with `copy_ready_i`. While it is high, `copy_src_o` equals the index of the unit being vacated. From the first cycle of the copy until the handover, both bits of `unit_gate_o` are 0.
- R8: After the handshake, the controller waits with `copy_valid_o` low and the stall held. In the cycle after `copy_done_i` is sampled high, `issue_stall_o` falls, the other unit is enabled and the vacated unit's `unit_gate_o` bit rises, all together.
- R9: Each finished move flips `active_o`, so the units strictly alternate.
- R10: While a move is under way, trigger conditions (a hot working unit, or the period elapsing) have no effect: no step is skipped or repeated and `active_o` holds until the handover.
- R11: `mig_count_o` goes up by one at each handover and stays at its all-ones value once it has got there.
- R12: `active_o` is always the index of the one bit set in `unit_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_sensor_i | input | 1 | Trigger select: 0 = periodic, 1 = temperature |
| period_i | input | PERIOD_W | Run cycles between moves; 0 disables migration |
| threshold_i | input | TEMP_W | Temperature limit for sensor mode |
| temp0_i | input | TEMP_W | Temperature reading of unit 0 |
| temp1_i | input | TEMP_W | Temperature reading of unit 1 |
| drain_done_i | input | 1 | Working unit has no operations in flight |
| copy_ready_i | input | 1 | Copy engine accepts the state-transfer request |
| copy_done_i | input | 1 | Pulse: state transfer finished |
| issue_stall_o | output | 1 | Blocks new work from being issued |
| unit_en_o | output | 2 | Per-unit enable |
| unit_gate_o | output | 2 | Per-unit active-power gate (1 = gated off) |
| copy_valid_o | output | 1 | State-transfer request |
| copy_src_o | output | 1 | Index of the unit whose state is copied |
| active_o | output | 1 | Index of the unit currently in charge |
| mig_count_o | output | CNT_W | Saturating count of finished moves |

## Verification
The assertions assume that `drain_done_i` and `copy_done_i` arrive as single-cycle pulses, and only in the phase that waits for them. They also assume that `period_i` changes only while no run-cycle count is close to the new value, so that the bound on the period counter applies after any change. The bench keeps to these assumptions. It changes period, threshold and mode only in the first run cycle after a handover, and raises each handshake input for exactly one cycle, once the outputs show that the matching phase has been reached. Temperatures are driven away from the clock edge. The working unit is kept hot through the drain and copy phases and the idle unit is held at full scale, to exercise the cases where the reading must be ignored.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int NUM_UNITS = 2;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_DRAIN     = 2'd1,
        ST_COPY_REQ  = 2'd2,
        ST_COPY_WAIT = 2'd3
    } swap_state_e;

    typedef enum logic {
        TRIG_PERIODIC = 1'b0,
        TRIG_THERMAL  = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic en;
        logic gate;
    } unit_ctl_t;

    function automatic logic partner(input logic idx);
        return ~idx;
    endfunction

    function automatic logic is_migrating(input swap_state_e s);
        return s != ST_RUN;
    endfunction

endpackage

// File: rtl/hp_period_trigger.sv
module hp_period_trigger
    import hp_pkg::*;
#(
    parameter int PERIOD_W = 32,
    parameter int TEMP_W   = 10
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 run_i,
    input  trig_mode_e                           mode_i,
    input  logic [PERIOD_W-1:0]                  period_i,
    input  logic [TEMP_W-1:0]                    threshold_i,
    input  logic [NUM_UNITS-1:0][TEMP_W-1:0]     temps_i,
    input  logic                                 active_i,
    output logic                                 fire_o
);

    localparam int CW = PERIOD_W + 1;

    logic [PERIOD_W-1:0] cnt_q;
    logic [CW-1:0]       cnt_next_ext;
    logic                enabled;
    logic                period_hit;
    logic                too_hot;
    logic [TEMP_W-1:0]   temp_act;

    assign enabled      = (period_i != '0);
    assign cnt_next_ext = {1'b0, cnt_q} + CW'(1);
    assign period_hit   = (cnt_next_ext >= {1'b0, period_i});
    assign temp_act     = temps_i[active_i];
    assign too_hot      = (temp_act > threshold_i);

    always_comb begin
        fire_o = 1'b0;
        if (run_i && enabled) begin
            fire_o = (mode_i == TRIG_THERMAL) ? too_hot : period_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i || fire_o) begin
            cnt_q <= '0;
        end else if (!period_hit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the run-cycle count never reaches a steady nonzero period
    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (run_i && enabled && $stable(period_i)) |-> (cnt_q < period_i));

endmodule

// File: rtl/hp_swap_fsm.sv
module hp_swap_fsm
    import hp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fire_i,
    input  logic        drain_done_i,
    input  logic        copy_ready_i,
    input  logic        copy_done_i,
    output swap_state_e state_o,
    output logic        active_o,
    output logic        handover_o
);

    swap_state_e state_q;
    swap_state_e state_d;
    logic        active_q;

    assign handover_o = (state_q == ST_COPY_WAIT) && copy_done_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:       if (fire_i)       state_d = ST_DRAIN;
            ST_DRAIN:     if (drain_done_i) state_d = ST_COPY_REQ;
            ST_COPY_REQ:  if (copy_ready_i) state_d = ST_COPY_WAIT;
            ST_COPY_WAIT: if (copy_done_i)  state_d = ST_RUN;
            default:                        state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RUN;
            active_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (handover_o) begin
                active_q <= partner(active_q);
            end
        end
    end

    assign state_o  = state_q;
    assign active_o = active_q;

    // R6: draining lasts until the drain-done input is seen
    p_wait_drain_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DRAIN && !drain_done_i) |=> (state_q == ST_DRAIN));

    // R7: the copy request is held until accepted
    p_valid_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COPY_REQ && !copy_ready_i) |=> (state_q == ST_COPY_REQ));

    // R9: every handover flips the working unit
    p_alternate_r9: assert property (@(posedge clk) disable iff (rst)
        handover_o |=> (active_q != $past(active_q)));

    // R10: mid-move, nothing but the done pulse ends the move
    p_ignore_midswap_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RUN && !handover_o) |=> ($stable(active_q) && state_q != ST_RUN));

endmodule

// File: rtl/hp_unit_ctl.sv
module hp_unit_ctl
    import hp_pkg::*;
(
    input  swap_state_e          state_i,
    input  logic                 active_i,
    output logic [NUM_UNITS-1:0] unit_en_o,
    output logic [NUM_UNITS-1:0] unit_gate_o,
    output logic                 stall_o,
    output logic                 copy_valid_o
);

    logic gate_idle_phase;

    assign gate_idle_phase = (state_i == ST_RUN) || (state_i == ST_DRAIN);
    assign stall_o         = is_migrating(state_i);
    assign copy_valid_o    = (state_i == ST_COPY_REQ);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        unit_ctl_t ctl;
        always_comb begin
            ctl.en   = (active_i == 1'(u));
            ctl.gate = !ctl.en && gate_idle_phase;
        end
        assign unit_en_o[u]   = ctl.en;
        assign unit_gate_o[u] = ctl.gate;
    end

endmodule

// File: rtl/hp_sat_count.sv
module hp_sat_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
        end else if (inc_i && count_o != MAX) begin
            count_o <= count_o + 1'b1;
        end
    end

    // R11: once full, the count stays full
    p_saturate_r11: assert property (@(posedge clk) disable iff (rst)
        (count_o == MAX) |=> (count_o == MAX));

    // R11: the count only ever steps up by one
    p_step_r11: assert property (@(posedge clk) disable iff (rst)
        (count_o != $past(count_o)) |-> (count_o == $past(count_o) + W'(1)));

endmodule

// File: rtl/heat_pingpong_ctrl.sv
module heat_pingpong_ctrl
    import hp_pkg::*;
#(
    parameter int PERIOD_W = 32,
    parameter int TEMP_W   = 10,
    parameter int CNT_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig_sensor_i,
    input  logic [PERIOD_W-1:0]  period_i,
    input  logic [TEMP_W-1:0]    threshold_i,
    input  logic [TEMP_W-1:0]    temp0_i,
    input  logic [TEMP_W-1:0]    temp1_i,
    input  logic                 drain_done_i,
    input  logic                 copy_ready_i,
    input  logic                 copy_done_i,
    output logic                 issue_stall_o,
    output logic [1:0]           unit_en_o,
    output logic [1:0]           unit_gate_o,
    output logic                 copy_valid_o,
    output logic                 copy_src_o,
    output logic                 active_o,
    output logic [CNT_W-1:0]     mig_count_o
);

    trig_mode_e                          mode;
    logic [NUM_UNITS-1:0][TEMP_W-1:0]    temps;
    swap_state_e                         state;
    logic                                fire;
    logic                                handover;
    logic                                active;
    logic                                in_run;

    assign mode   = trig_mode_e'(trig_sensor_i);
    assign temps  = {temp1_i, temp0_i};
    assign in_run = (state == ST_RUN);

    hp_period_trigger #(
        .PERIOD_W (PERIOD_W),
        .TEMP_W   (TEMP_W)
    ) i_trig (
        .clk         (clk),
        .rst         (rst),
        .run_i       (in_run),
        .mode_i      (mode),
        .period_i    (period_i),
        .threshold_i (threshold_i),
        .temps_i     (temps),
        .active_i    (active),
        .fire_o      (fire)
    );

    hp_swap_fsm i_fsm (
        .clk          (clk),
        .rst          (rst),
        .fire_i       (fire),
        .drain_done_i (drain_done_i),
        .copy_ready_i (copy_ready_i),
        .copy_done_i  (copy_done_i),
        .state_o      (state),
        .active_o     (active),
        .handover_o   (handover)
    );

    hp_unit_ctl i_units (
        .state_i      (state),
        .active_i     (active),
        .unit_en_o    (unit_en_o),
        .unit_gate_o  (unit_gate_o),
        .stall_o      (issue_stall_o),
        .copy_valid_o (copy_valid_o)
    );

    hp_sat_count #(
        .W (CNT_W)
    ) i_count (
        .clk     (clk),
        .rst     (rst),
        .inc_i   (handover),
        .count_o (mig_count_o)
    );

    assign active_o   = active;
    assign copy_src_o = active;

    // R1: reset leaves unit 0 in charge with a cleared count
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (active_o == 1'b0 && mig_count_o == '0 && !issue_stall_o));

    // R2: exactly one unit enabled at all times
    p_one_enabled_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(unit_en_o) == 1);

    // R2: outside a move the idle unit is gated
    p_idle_gated_r2: assert property (@(posedge clk) disable iff (rst)
        !issue_stall_o |-> (unit_gate_o == ~unit_en_o));

    // R4: a zero period keeps the block running where it is
    p_zero_period_r4: assert property (@(posedge clk) disable iff (rst)
        (!issue_stall_o && period_i == '0) |=> !issue_stall_o);

    // R5: a hot working unit starts a move in sensor mode
    p_thermal_fire_r5: assert property (@(posedge clk) disable iff (rst)
        (trig_sensor_i && !issue_stall_o && period_i != '0 &&
         ((active_o ? temp1_i : temp0_i) > threshold_i)) |=> issue_stall_o);

    // R8: stall release coincides with a change of working unit
    p_stall_release_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(issue_stall_o) |-> (active_o != $past(active_o)));

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_gate_chk
        // R8: a unit is gated off only after the copy-done pulse
        p_gate_after_done_r8: assert property (@(posedge clk) disable iff (rst)
            $rose(unit_gate_o[u]) |-> $past(copy_done_i));
    end

    // R12: status names the enabled unit
    p_status_r12: assert property (@(posedge clk) disable iff (rst)
        unit_en_o == (active_o ? 2'b10 : 2'b01));

endmodule

// File: tb/test_heat_pingpong_ctrl.sv
module test_heat_pingpong_ctrl;

    localparam int PW = 32;
    localparam int TW = 10;
    localparam int CW = 8;
    localparam int CMAX = 255;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig_sensor = 1'b0;
    logic [PW-1:0] period = 32'd5;
    logic [TW-1:0] threshold = 10'd500;
    logic [TW-1:0] temp0 = '0;
    logic [TW-1:0] temp1 = '0;
    logic          drain_done = 1'b0;
    logic          copy_ready = 1'b0;
    logic          copy_done = 1'b0;
    logic          issue_stall;
    logic [1:0]    unit_en;
    logic [1:0]    unit_gate;
    logic          copy_valid;
    logic          copy_src;
    logic          active;
    logic [CW-1:0] mig_count;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int exp_active = 0;
    int exp_count = 0;

    always #10 clk = ~clk;

    heat_pingpong_ctrl #(.PERIOD_W(PW), .TEMP_W(TW), .CNT_W(CW)) i_heat_pingpong_ctrl (
        .clk           (clk),
        .rst           (rst),
        .trig_sensor_i (trig_sensor),
        .period_i      (period),
        .threshold_i   (threshold),
        .temp0_i       (temp0),
        .temp1_i       (temp1),
        .drain_done_i  (drain_done),
        .copy_ready_i  (copy_ready),
        .copy_done_i   (copy_done),
        .issue_stall_o (issue_stall),
        .unit_en_o     (unit_en),
        .unit_gate_o   (unit_gate),
        .copy_valid_o  (copy_valid),
        .copy_src_o    (copy_src),
        .active_o      (active),
        .mig_count_o   (mig_count)
    );

    typedef struct packed {
        logic       mode;
        logic [15:0] per;
        logic [9:0] thr;
        logic [7:0] hot_at;
        logic [7:0] dd;
        logic [7:0] rd;
        logic [7:0] cd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'd5,    10'd500,  8'd0,  8'd0, 8'd0, 8'd0},
        '{1'b0, 16'd12,   10'd500,  8'd0,  8'd3, 8'd2, 8'd4},
        '{1'b1, 16'd100,  10'd300,  8'd7,  8'd1, 8'd0, 8'd2},
        '{1'b1, 16'd100,  10'd600,  8'd1,  8'd0, 8'd3, 8'd0},
        '{1'b0, 16'd1,    10'd500,  8'd0,  8'd2, 8'd1, 8'd1},
        '{1'b1, 16'd9,    10'd200,  8'd20, 8'd0, 8'd0, 8'd5},
        '{1'b0, 16'd30,   10'd500,  8'd0,  8'd5, 8'd5, 8'd5},
        '{1'b1, 16'd1000, 10'd1022, 8'd3,  8'd2, 8'd2, 8'd2}
    };

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // Set the working unit's temperature; the idle unit stays at full scale.
    task automatic set_temps(input logic [TW-1:0] act_t);
        if (exp_active == 0) begin temp0 = act_t;  temp1 = 10'h3FF; end
        else                 begin temp1 = act_t;  temp0 = 10'h3FF; end
    endtask

    // One full move; entered at a negedge in the first run cycle.
    task automatic do_mig(input logic mode, input int per, input int thr,
                          input int hot_at, input int dd, input int rd, input int cd);
        int run_len;
        int old;
        run_len = 0;
        old = exp_active;
        trig_sensor = mode;
        period = PW'(per);
        threshold = TW'(thr);
        set_temps('0);
        while (issue_stall == 1'b0 && run_len < 5000) begin
            run_len++;
            if (mode && run_len == hot_at) set_temps(TW'(thr + 1));
            @(negedge clk);
        end
        // R3 / R5: length of the stall-free run
        check(mode ? "R5 run length" : "R3 run length", run_len, mode ? hot_at : per);
        // drain phase
        for (int i = 0; i <= dd; i++) begin
            check("R6 no copy during drain", copy_valid, 0);
            check("R6 stall in drain", issue_stall, 1);
            check("R10 active held in drain", active, old);
            if (i == dd) drain_done = 1'b1;
            @(negedge clk);
        end
        drain_done = 1'b0;
        // copy request phase
        for (int i = 0; i <= rd; i++) begin
            check("R7 copy valid", copy_valid, 1);
            check("R7 copy source", copy_src, old);
            check("R7 both ungated", unit_gate, 0);
            if (i == rd) copy_ready = 1'b1;
            @(negedge clk);
        end
        copy_ready = 1'b0;
        // copy wait phase
        for (int i = 0; i <= cd; i++) begin
            check("R8 valid dropped", copy_valid, 0);
            check("R8 stall held", issue_stall, 1);
            check("R10 active held in copy", active, old);
            if (i == cd) copy_done = 1'b1;
            @(negedge clk);
        end
        copy_done = 1'b0;
        exp_active = 1 - old;
        if (exp_count < CMAX) exp_count++;
        check("R8 stall released", issue_stall, 0);
        check("R8 old unit gated", unit_gate, (old == 0) ? 1 : 2);
        check("R9 alternation", active, exp_active);
        check("R12 enable matches status", unit_en, (exp_active == 0) ? 1 : 2);
        check("R11 count", mig_count, exp_count);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, also the first run cycle
        check("R1 active", active, 0);
        check("R1 enable", unit_en, 1);
        check("R1 gate", unit_gate, 2);
        check("R1 stall", issue_stall, 0);
        check("R1 copy valid", copy_valid, 0);
        check("R1 count", mig_count, 0);

        for (int v = 0; v < NV; v++) begin
            do_mig(VECS[v].mode, int'(VECS[v].per), int'(VECS[v].thr), int'(VECS[v].hot_at),
                   int'(VECS[v].dd), int'(VECS[v].rd), int'(VECS[v].cd));
        end

        // R4: zero period in periodic mode
        trig_sensor = 1'b0;
        period = '0;
        begin
            int stalls = 0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (issue_stall) stalls++;
            end
            check("R4 periodic zero period stalls", stalls, 0);
            check("R4 periodic zero period active", active, exp_active);
        end
        // R4: zero period in sensor mode with a hot working unit
        trig_sensor = 1'b1;
        threshold = 10'd100;
        set_temps(10'd900);
        begin
            int stalls = 0;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk);
                if (issue_stall) stalls++;
            end
            check("R4 sensor zero period stalls", stalls, 0);
            check("R4 sensor zero period active", active, exp_active);
        end
        // R5: reading equal to threshold does not trigger; idle unit ignored
        period = 32'd10;
        threshold = 10'd400;
        set_temps(10'd400);
        begin
            int stalls = 0;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk);
                if (issue_stall) stalls++;
            end
            check("R5 equal reading no trigger", stalls, 0);
            check("R5 idle hot ignored", active, exp_active);
        end
        do_mig(1'b1, 10, 400, 1, 0, 0, 0);

        // R11: drive the count to saturation and beyond
        while (exp_count < CMAX) begin
            do_mig(1'b0, 1, 500, 0, 0, 0, 0);
        end
        do_mig(1'b0, 1, 500, 0, 1, 0, 0);
        do_mig(1'b0, 2, 500, 0, 0, 1, 0);
        check("R11 saturated", mig_count, CMAX);

        finish_run();
    end

endmodule